// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Controller

This block keeps the pending flags and the enable bits for the interrupt sources of two timers. It turns them into one interrupt request and a vector number for the CPU. There are three sources: a compare match on timer 1 against its compare register A, an overflow of timer 1, and an overflow of timer 0. Each timer raises its source with a single-cycle event pulse. The flag stays set until software writes a one to it, or until the CPU acknowledges that source's vector.

Software reaches the block through a byte-wide register port. A select input picks the flag register or the enable register, and read data is combinational. A request for a source goes out only when three bits are all set: the global interrupt enable, that source's enable bit and that source's flag. When several sources are pending at once, the source with the lowest vector number is presented.

Top module: `tirq_ctrl`

## Requirements
- R1: After a synchronous reset, every flag bit and every enable bit is 0, `irq` is 0 and `irq_vector` is 0.
- R2: With `reg_sel`=0 the read data is the flag register: compare-match flag at bit 6, timer-1 overflow flag at bit 2, timer-0 overflow flag at bit 1. Bits 7, 5, 4, 3 and 0 always read 0.
- R3: With `reg_sel`=1 the read data is the enable register, with enables at bit 6 (compare match), bit 2 (timer-1 overflow) and bit 1 (timer-0 overflow). A write with `reg_sel`=1 loads these bits. Other bit positions ignore writes and read 0. The register holds its value when it is not written.
- R4: An event pulse on an input sets the matching flag. The flag reads as 1 from the cycle after the event.
- R5: A write with `reg_sel`=0 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: `ack_valid` together with `ack_vector` equal to a source's vector clears only that source's flag. An acknowledge of a vector whose flag is clear changes nothing.
- R7: If an event and a clear (by write or by acknowledge) reach the same flag in the same cycle, the flag ends up 1.
- R8: `irq` is 1 only when `gie` is 1 and at least one source has both its flag and its enable bit set.
- R9: The vector numbers are 3 for compare match, 4 for timer-1 overflow and 5 for timer-0 overflow.
- R10: When several sources request at once, `irq_vector` shows the lowest vector number among them.
- R11: `irq_vector` is 0 whenever `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt_cmpa | input | 1 | Timer-1 compare match A event pulse |
| evt_ovf1 | input | 1 | Timer-1 overflow event pulse |
| evt_ovf0 | input | 1 | Timer-0 overflow event pulse |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | CPU acknowledges a vector this cycle |
| ack_vector | input | 3 | Vector number being acknowledged |
| irq | output | 1 | Interrupt request |
| irq_vector | output | 3 | Vector of the highest-priority request, 0 when idle |

## Verification
The assertions check on every cycle that each flag follows its rules: an event sets it, a clear without an event drops it, and otherwise it holds. They also check that the enable register holds when it is not written, that `irq` never rises without `gie`, that the vector is 0 when no request is out, and that a live compare-match request always wins. Some behaviour can only be shown by the bench's scenarios, because it needs values computed independently at the ports. That covers the bit positions seen through read data, write-one clear and write-zero hold, an acknowledge that clears only its own source, set winning over a same-cycle clear, masking by individual enables, and the exact vector chosen when sources overlap.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 3;
    localparam int VEC_W   = 3;

    // source index order is also priority order (index 0 highest)
    typedef enum logic [1:0] {
        SRC_CMPA = 2'd0,
        SRC_OVF1 = 2'd1,
        SRC_OVF0 = 2'd2
    } src_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } irq_req_t;

    // bit position of a source in both the flag and the enable register
    function automatic int src_bit(input int s);
        case (s)
            int'(SRC_CMPA): return 6;
            int'(SRC_OVF1): return 2;
            default:        return 1;
        endcase
    endfunction

    // vector number of a source
    function automatic logic [VEC_W-1:0] src_vec(input int s);
        return VEC_W'(3 + s);
    endfunction

    // implemented bits of the register byte
    function automatic logic [DATA_W-1:0] impl_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) m[src_bit(s)] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_bits();

endpackage

// File: rtl/tirq_flag_bank.sv
module tirq_flag_bank
    import tirq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] wclr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (evt[g])
                flag_q <= 1'b1;          // set has priority over any clear
            else if (wclr[g] || ack_clr[g])
                flag_q <= 1'b0;
        end

        assign flags[g] = flag_q;

        assert_evt_sets_R4: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> flags[g]);

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            (evt[g] && (wclr[g] || ack_clr[g])) |=> flags[g]);

        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (!evt[g] && (wclr[g] || ack_clr[g])) |=> !flags[g]);

        assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (!evt[g] && !wclr[g] && !ack_clr[g]) |=> $stable(flags[g]));
    end

endmodule

// File: rtl/tirq_mask_reg.sv
module tirq_mask_reg
    import tirq_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (we)
            mask_q <= wdata & W'(IMPL_MASK);
    end

    assign mask = mask_q;

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mask));

    assert_mask_rsv_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> ((mask & ~W'(IMPL_MASK)) == '0));

endmodule

// File: rtl/tirq_arbiter.sv
module tirq_arbiter
    import tirq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    input  logic         gie,
    output irq_req_t     req
);

    always_comb begin
        req = '0;
        if (gie) begin
            for (int s = N - 1; s >= 0; s--) begin
                if (pend[s]) begin
                    req.valid = 1'b1;
                    req.vec   = src_vec(s);
                end
            end
        end
    end

endmodule

// File: rtl/tirq_ctrl.sv
module tirq_ctrl
    import tirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             evt_cmpa,
    input  logic             evt_ovf1,
    input  logic             evt_ovf0,
    input  logic             gie,
    input  logic             ack_valid,
    input  logic [2:0]       ack_vector,
    output logic             irq,
    output logic [2:0]       irq_vector
);

    logic [NUM_SRC-1:0] evt, wclr, ack_clr, flags, en;
    logic [DATA_W-1:0]  mask_byte, flag_byte;
    irq_req_t           req;

    assign evt[int'(SRC_CMPA)] = evt_cmpa;
    assign evt[int'(SRC_OVF1)] = evt_ovf1;
    assign evt[int'(SRC_OVF0)] = evt_ovf0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int B = src_bit(g);
        assign wclr[g]    = reg_wr && !reg_sel && reg_wdata[B];
        assign ack_clr[g] = ack_valid && (ack_vector == src_vec(g));
        assign en[g]      = mask_byte[B];
    end

    always_comb begin
        flag_byte = '0;
        for (int s = 0; s < NUM_SRC; s++) flag_byte[src_bit(s)] = flags[s];
    end

    tirq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .wclr    (wclr),
        .ack_clr (ack_clr),
        .flags   (flags)
    );

    tirq_mask_reg #(.W(DATA_W)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_wr && reg_sel),
        .wdata (reg_wdata),
        .mask  (mask_byte)
    );

    tirq_arbiter #(.N(NUM_SRC)) u_arb (
        .pend (flags & en),
        .gie  (gie),
        .req  (req)
    );

    assign reg_rdata  = reg_sel ? mask_byte : flag_byte;
    assign irq        = req.valid;
    assign irq_vector = req.valid ? req.vec : '0;

    assert_irq_needs_gie_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie);

    assert_irq_needs_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & en) != '0));

    assert_idle_vector_R11: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_vector == '0));

    assert_cmpa_first_R10: assert property (@(posedge clk) disable iff (rst)
        (gie && flags[int'(SRC_CMPA)] && en[int'(SRC_CMPA)]) |-> (irq_vector == 3'd3));

    assert_rsv_read_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~IMPL_MASK) == '0);

endmodule

// File: tb/sim_tirq_ctrl.sv
module sim_tirq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, reg_sel, reg_wr, evt_cmpa, evt_ovf1, evt_ovf0, gie, ack_valid;
    logic [7:0] reg_wdata, reg_rdata;
    logic [2:0] ack_vector, irq_vector;
    logic       irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tirq_ctrl u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_cmpa(evt_cmpa), .evt_ovf1(evt_ovf1), .evt_ovf0(evt_ovf0),
        .gie(gie), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .irq(irq), .irq_vector(irq_vector)
    );

    typedef struct {
        string      tag;
        logic       irq;
        logic [2:0] vec;
        logic [7:0] rdata;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    logic [7:0] m_flag = '0;
    logic [7:0] m_mask = '0;

    function automatic logic [7:0] vec_bit(input logic [2:0] v);
        case (v)
            3'd3:    return 8'h40;
            3'd4:    return 8'h04;
            3'd5:    return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(input string tag, input logic r, input logic sel,
                        input logic wr, input logic [7:0] wd, input logic [2:0] ev,
                        input logic g, input logic av, input logic [2:0] avec);
        exp_t       e;
        logic [7:0] set_b, clr_b, pend;
        @(negedge clk);
        rst = r; reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        evt_cmpa = ev[0]; evt_ovf1 = ev[1]; evt_ovf0 = ev[2];
        gie = g; ack_valid = av; ack_vector = avec;
        if (r) begin
            m_flag = '0; m_mask = '0;
        end else begin
            set_b = {1'b0, ev[0], 3'b0, ev[1], ev[2], 1'b0};
            clr_b = ((wr && !sel) ? (wd & 8'h46) : 8'h00) | (av ? vec_bit(avec) : 8'h00);
            m_flag = set_b | (m_flag & ~clr_b);
            if (wr && sel) m_mask = wd & 8'h46;
        end
        pend    = m_flag & m_mask;
        e.tag   = tag;
        e.irq   = g && (pend != 0);
        e.vec   = !e.irq ? 3'd0 : pend[6] ? 3'd3 : pend[2] ? 3'd4 : 3'd5;
        e.rdata = sel ? m_mask : m_flag;
        exp_q.push_back(e);
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: results are visible just after the edge that follows the drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "irq", int'(irq), int'(e.irq));
                check(e.tag, "irq_vector", int'(irq_vector), int'(e.vec));
                check(e.tag, "reg_rdata", int'(reg_rdata), int'(e.rdata));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; reg_sel = 0; reg_wr = 0; reg_wdata = 0;
        evt_cmpa = 0; evt_ovf1 = 0; evt_ovf0 = 0; gie = 0; ack_valid = 0; ack_vector = 0;
        //    tag     rst sel wr  wdata  ev(ovf0,ovf1,cmpa) gie ack vec
        step("R1",   1, 0, 0, 8'h00, 3'b000, 0, 0, 3'd0);
        step("R1",   1, 1, 0, 8'h00, 3'b000, 1, 0, 3'd0);
        step("R4",   0, 0, 0, 8'h00, 3'b001, 0, 0, 3'd0);
        step("R2",   0, 0, 0, 8'h00, 3'b110, 0, 0, 3'd0);
        step("R3",   0, 1, 1, 8'hFF, 3'b000, 0, 0, 3'd0);
        step("R8",   0, 1, 0, 8'h00, 3'b000, 0, 0, 3'd0);
        step("R10",  0, 0, 0, 8'h00, 3'b000, 1, 0, 3'd0);
        step("R5",   0, 0, 1, 8'h40, 3'b000, 1, 0, 3'd0);
        step("r5_zero", 0, 0, 1, 8'h00, 3'b000, 1, 0, 3'd0);
        step("R6",   0, 0, 0, 8'h00, 3'b000, 1, 1, 3'd4);
        step("R9",   0, 0, 0, 8'h00, 3'b000, 1, 1, 3'd3);
        step("R7",   0, 0, 1, 8'h40, 3'b001, 1, 0, 3'd0);
        step("R8",   0, 1, 1, 8'h02, 3'b000, 1, 0, 3'd0);
        step("R11",  0, 1, 1, 8'h00, 3'b000, 1, 0, 3'd0);
        step("R5",   0, 0, 1, 8'hFF, 3'b000, 1, 0, 3'd0);
        step("R2",   0, 0, 1, 8'hB9, 3'b000, 1, 0, 3'd0);
        step("R3",   0, 1, 1, 8'h04, 3'b000, 1, 0, 3'd0);
        step("R9",   0, 0, 0, 8'h00, 3'b010, 1, 0, 3'd0);
        step("R3",   0, 1, 0, 8'hFF, 3'b000, 1, 0, 3'd0);
        step("R7",   0, 1, 1, 8'h06, 3'b100, 1, 1, 3'd5);
        step("R10",  0, 0, 0, 8'h00, 3'b000, 1, 1, 3'd4);
        step("R9",   0, 0, 0, 8'h00, 3'b000, 1, 0, 3'd0);
        step("R8",   0, 0, 0, 8'h00, 3'b000, 0, 0, 3'd0);
        step("R1",   1, 0, 0, 8'h00, 3'b000, 1, 0, 3'd0);
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule